// File: doc/BRIEF.md
# E1 Packed Error Counter Bank

This block keeps three performance counters for an E1 receive framer. The first is a 12-bit count of errored frame alignment words seen in timeslot 0. The second is a 10-bit count of CRC-4 errors. The third is a 10-bit count of E-bits. The framer drives a single-cycle increment strobe for each counter, plus a level that is high while basic frame synchronization is lost. The alignment-word counter stops while that level is high. It keeps running when only the CAS or CRC-4 multiframe has lost lock.

A one-second strobe copies all three live counts into held copies in a single cycle and restarts the live counts. A processor reads the held copies through an 8-bit port at fixed byte addresses. Fields of different counters share a byte there, so software joins the pieces back together.

Top module: `e1_perf_counter_bank`

## Requirements
- R1: After synchronous reset, every read address returns 0x00 until a one-second strobe has latched nonzero counts.
- R2: Each cycle with `fas_err_inc` high and `frame_lost` low adds one to the live alignment-word count. The count becomes readable after the next `sec_tick`.
- R3: While `frame_lost` is high, `fas_err_inc` has no effect on the alignment-word count. `frame_lost` does not affect the CRC-4 or E-bit counts.
- R4: Address 0x02 reads alignment count bits 11..6 in data bits 7..2, and CRC-4 count bits 9..8 in data bits 1..0.
- R5: Address 0x03 reads CRC-4 count bits 7..0 in data bits 7..0.
- R6: Address 0x04 reads alignment count bits 5..0 in data bits 7..2, and E-bit count bits 9..8 in data bits 1..0.
- R7: Address 0x05 reads E-bit count bits 7..0 in data bits 7..0.
- R8: Every other address reads 0x00.
- R9: On a `sec_tick` cycle, all three held copies take the live counts from before that cycle's increments. Each live count restarts at 1 if its increment is accepted in that cycle, and at 0 otherwise.
- R10: The 10-bit counters stop at 1023 and the 12-bit counter stops at 4095; none of them wraps.
- R11: `rd_data` is registered. It shows the held values at `rd_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fas_err_inc | input | 1 | Errored alignment word strobe |
| crc_err_inc | input | 1 | CRC-4 error strobe |
| ebit_inc | input | 1 | E-bit strobe |
| frame_lost | input | 1 | Basic frame synchronization lost |
| sec_tick | input | 1 | One-second latch strobe |
| rd_addr | input | ADDR_W (8) | Read byte address |
| rd_data | output | 8 | Registered read data |

## Verification
The bench builds the block with its default widths: an 8-bit address, a 12-bit alignment counter and two 10-bit counters. With these widths the 1023 stop point is reached in about a thousand strobes. A long burst of CRC-4 and E-bit strobes with no second tick therefore drives both small counters into saturation. Frame-loss windows, ticks that coincide with strobes, and a read address that sweeps through all eight low addresses exercise every packed byte, the unused addresses and the hold rule.

// File: rtl/e1pc_pkg.sv
package e1pc_pkg;
  localparam int FAS_W  = 12;
  localparam int AUX_W  = 10;
  localparam int DATA_W = 8;
  localparam int HI_W   = DATA_W - (AUX_W - DATA_W); // alignment bits per byte
  localparam logic [7:0] ADDR_FAS_HI = 8'h02;
  localparam logic [7:0] ADDR_CRC_LO = 8'h03;
  localparam logic [7:0] ADDR_FAS_LO = 8'h04;
  localparam logic [7:0] ADDR_EB_LO  = 8'h05;
endpackage

// File: rtl/e1pc_channel.sv
module e1pc_channel #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         en,
  input  logic         latch,
  output logic [W-1:0] live,
  output logic [W-1:0] held
);
  localparam logic [W-1:0] TOP = '1;
  logic take;
  assign take = inc && en;

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
      held <= '0;
    end else if (latch) begin
      held <= live;
      live <= take ? W'(1) : '0;
    end else if (take && live != TOP) begin
      live <= live + W'(1);
    end
  end
endmodule

// File: rtl/e1pc_readmux.sv
module e1pc_readmux
  import e1pc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [FAS_W-1:0]  fas_held,
  input  logic [AUX_W-1:0]  crc_held,
  input  logic [AUX_W-1:0]  eb_held,
  output logic [DATA_W-1:0] data
);
  localparam int SPLIT = AUX_W - DATA_W;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = '0;
    if (ADDR_W'(ADDR_FAS_HI) == addr)
      nxt = {fas_held[FAS_W-1 -: HI_W], crc_held[AUX_W-1 -: SPLIT]};
    else if (ADDR_W'(ADDR_CRC_LO) == addr)
      nxt = crc_held[DATA_W-1:0];
    else if (ADDR_W'(ADDR_FAS_LO) == addr)
      nxt = {fas_held[HI_W-1:0], eb_held[AUX_W-1 -: SPLIT]};
    else if (ADDR_W'(ADDR_EB_LO) == addr)
      nxt = eb_held[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) data <= '0;
    else     data <= nxt;
  end
endmodule

// File: rtl/e1_perf_counter_bank.sv
module e1_perf_counter_bank
  import e1pc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fas_err_inc,
  input  logic              crc_err_inc,
  input  logic              ebit_inc,
  input  logic              frame_lost,
  input  logic              sec_tick,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic [FAS_W-1:0] fas_live, fas_held;
  logic [AUX_W-1:0] crc_live, crc_held;
  logic [AUX_W-1:0] eb_live,  eb_held;

  // alignment-word count halts only on basic frame loss
  e1pc_channel #(.W(FAS_W)) u_fas (
    .clk(clk), .rst(rst), .inc(fas_err_inc), .en(!frame_lost),
    .latch(sec_tick), .live(fas_live), .held(fas_held));

  e1pc_channel #(.W(AUX_W)) u_crc (
    .clk(clk), .rst(rst), .inc(crc_err_inc), .en(1'b1),
    .latch(sec_tick), .live(crc_live), .held(crc_held));

  e1pc_channel #(.W(AUX_W)) u_eb (
    .clk(clk), .rst(rst), .inc(ebit_inc), .en(1'b1),
    .latch(sec_tick), .live(eb_live), .held(eb_held));

  e1pc_readmux #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .addr(rd_addr),
    .fas_held(fas_held), .crc_held(crc_held), .eb_held(eb_held),
    .data(rd_data));
endmodule

// File: rtl/e1pc_checker.sv
module e1pc_checker #(
  parameter int ADDR_W = 8,
  parameter int FW = 12,
  parameter int AW = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              fas_err_inc,
  input logic              frame_lost,
  input logic              sec_tick,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic [FW-1:0]     fas_live,
  input logic [FW-1:0]     fas_held,
  input logic [AW-1:0]     crc_live,
  input logic [AW-1:0]     crc_held
);
  logic unused_addr;
  assign unused_addr = (rd_addr < ADDR_W'(2)) || (rd_addr > ADDR_W'(5));

  assert_frame_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (frame_lost && !sec_tick) |=> (fas_live == $past(fas_live)));

  assert_latch_copy_R9: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> (fas_held == $past(fas_live) && crc_held == $past(crc_live)));

  assert_latch_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !(fas_err_inc && !frame_lost)) |=> (fas_live == '0));

  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (crc_live == '1 && !sec_tick) |=> (crc_live == '1));

  assert_unused_zero_R8: assert property (@(posedge clk) disable iff (rst)
    unused_addr |=> (rd_data == 8'h00));
endmodule

bind e1_perf_counter_bank e1pc_checker #(.ADDR_W(ADDR_W), .FW(e1pc_pkg::FAS_W), .AW(e1pc_pkg::AUX_W)) u_chk (
  .clk(clk), .rst(rst), .fas_err_inc(fas_err_inc), .frame_lost(frame_lost),
  .sec_tick(sec_tick), .rd_addr(rd_addr), .rd_data(rd_data),
  .fas_live(fas_live), .fas_held(fas_held), .crc_live(crc_live), .crc_held(crc_held));

// File: tb/e1_perf_counter_bank_tb_top.sv
module e1_perf_counter_bank_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fi = 0, ci = 0, ei = 0, lost = 0, lat = 0;
  logic [7:0] addr = '0;
  logic [7:0] rd_data;

  int checks = 0, errors = 0, cyc = 0;
  int fl = 0, cl = 0, el = 0, fs = 0, cs = 0, es = 0;
  logic [7:0] exp_rd = '0;
  string tag = "R1";

  always #2 clk = ~clk; // 250 MHz

  e1_perf_counter_bank dut_i (
    .clk(clk), .rst(rst), .fas_err_inc(fi), .crc_err_inc(ci), .ebit_inc(ei),
    .frame_lost(lost), .sec_tick(lat), .rd_addr(addr), .rd_data(rd_data));

  function automatic logic [7:0] map_rd(input logic [7:0] a);
    logic [11:0] f; logic [9:0] c, e;
    f = 12'(fs); c = 10'(cs); e = 10'(es);
    case (a)
      8'h02:   return {f[11:6], c[9:8]};  // R4
      8'h03:   return c[7:0];             // R5
      8'h04:   return {f[5:0], e[9:8]};   // R6
      8'h05:   return e[7:0];             // R7
      default: return 8'h00;              // R8
    endcase
  endfunction

  task automatic check(input string r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%0h actual=%0h expected=%0h", r, addr, act, exp);
    end
  endtask

  // one cycle: compare registered read (R11), apply inputs, advance model
  task automatic step(input logic f, input logic c, input logic e,
                      input logic l, input logic t, input logic [7:0] a);
    string r;
    @(negedge clk);
    case (addr)
      8'h02: r = "R4"; 8'h03: r = "R5"; 8'h04: r = "R6"; 8'h05: r = "R7";
      default: r = "R8";
    endcase
    check({tag, "/", r, "/R11"}, rd_data, exp_rd);
    fi = f; ci = c; ei = e; lost = l; lat = t; addr = a;
    exp_rd = map_rd(a);
    if (t) begin // R9
      fs = fl; cs = cl; es = el;
      fl = (f && !l) ? 1 : 0; cl = c ? 1 : 0; el = e ? 1 : 0;
    end else begin
      if (f && !l && fl < 4095) fl++; // R2 R3 R10
      if (c && cl < 1023) cl++;
      if (e && el < 1023) el++;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: all addresses zero after reset
    tag = "R1";
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0, 8'(i % 8));
    // R2 R9: random strobes with periodic ticks
    tag = "R2_R9";
    for (int i = 0; i < 600; i++)
      step($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1), 0,
           (i % 97) == 96, 8'(i % 8));
    // R3: frame loss windows, ticks inside and outside them
    tag = "R3";
    for (int i = 0; i < 600; i++)
      step(1, $urandom_range(0, 1), $urandom_range(0, 1), (i % 50) < 30,
           (i % 71) == 70, 8'(i % 8));
    // R9: tick coincident with strobes, then tick with none
    tag = "R9";
    step(1, 1, 1, 0, 1, 8'h02);
    step(0, 0, 0, 0, 1, 8'h03);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 8'(i));
    // R10: saturate the 10-bit counters and a long alignment burst
    tag = "R10";
    for (int i = 0; i < 1100; i++) step(1, 1, 1, 0, 0, 8'(i % 8));
    step(0, 0, 0, 0, 1, 8'h02);
    for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, 8'(i % 8));
    step(0, 0, 0, 0, 1, 8'h03);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 8'(i));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule